// File: doc/BRIEF.md
# Qualified Circular Bus Trace Buffer

This block watches a snooped processor bus and keeps the latest cycles in a ring of storage. Each bus cycle comes with a valid strobe, a 40-bit record and three type flags: instruction fetch, memory access and I/O access. A two-bit mode input selects which cycles are kept. Every kept cycle is written at the current write pointer, the pointer advances and wraps, and a one-clock sync pulse marks the write.

A host can freeze the ring and read it back by offset from the oldest valid entry, so it does not need to work out the read position itself. When the stop mode is enabled, the block raises a halt request on the capture of the 64th word since the last arm. Recording then pauses until the host clears the request. Clearing it resumes recording without erasing anything.

Top module: `trace_ring`

## Requirements
- R1: After reset, wr_ptr is 0, wrapped is 0, sync is 0 and halt_req is 0.
- R2: A valid cycle is qualified by mode as follows. 2'b00 keeps every valid cycle. 2'b01 keeps cycles with is_fetch=1. 2'b10 keeps cycles with is_mem=1. 2'b11 keeps cycles with is_io=1. A cycle with cyc_valid=0 is never kept.
- R3: A qualified cycle that is not blocked is stored at wr_ptr, and wr_ptr advances by one on the same clock edge.
- R4: sync is high for exactly the one clock after each edge that stores a word, and low after every other edge.
- R5: wr_ptr wraps from DEPTH-1 to 0. wrapped goes to 1 on that edge and stays at 1 until reset.
- R6: rd_data combinationally returns the entry rd_idx places after the oldest valid entry. The oldest entry is at index 0 before a wrap and at wr_ptr after a wrap. rd_idx = DEPTH-1 after a wrap gives the newest entry.
- R7: While freeze=1, nothing is stored, wr_ptr and sync stay idle, and changing rd_idx has no effect on the stored contents.
- R8: With halt_en=1, halt_req rises on the edge that stores the 64th word counted since the last arm, and not earlier. While halt_req=1, nothing is stored.
- R9: With halt_en=0, halt_req never rises.
- R10: An arm pulse clears the word count and halt_req. The stored contents, wr_ptr and wrapped are kept.
- R11: A halt_clr pulse drops halt_req, recording resumes with the contents kept, and no further halt occurs until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Qualification mode (see R2) |
| halt_en | input | 1 | Enable halt request after 64 words |
| arm | input | 1 | Restart the word count and clear halt_req |
| halt_clr | input | 1 | Host clears halt_req and resumes |
| freeze | input | 1 | Stop recording for dump |
| cyc_valid | input | 1 | Bus cycle strobe |
| cyc_rec | input | 40 | Bus cycle record |
| is_fetch | input | 1 | Cycle is an instruction fetch |
| is_mem | input | 1 | Cycle is a memory access |
| is_io | input | 1 | Cycle is an I/O access |
| rd_idx | input | 7 | Read offset from the oldest entry |
| rd_data | output | 40 | Entry at the read offset |
| sync | output | 1 | One-clock pulse per stored word |
| halt_req | output | 1 | Halt request to the processor |
| wr_ptr | output | 7 | Next write position |
| wrapped | output | 1 | Ring has wrapped at least once |

## Verification
sync, wr_ptr, wrapped and halt_req are all registered. Each reflects a cycle presented before an edge immediately after that edge, so the bench drives one cycle, waits for the edge and samples one time unit later. rd_data is combinational from rd_idx and the stored words, so it is sampled one time unit after rd_idx changes. The bench keeps its own model of the ring contents, pointer and word count, and compares against it at those points. The 64th-word halt is checked both on the 63rd write, where it must stay low, and on the 64th.

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int DATA_W     = 40,
  parameter int DEPTH      = 128,
  parameter int STOP_AFTER = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(STOP_AFTER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              halt_en,
  input  logic              arm,
  input  logic              halt_clr,
  input  logic              freeze,
  input  logic              cyc_valid,
  input  logic [DATA_W-1:0] cyc_rec,
  input  logic              is_fetch,
  input  logic              is_mem,
  input  logic              is_io,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              sync,
  output logic              halt_req,
  output logic [AW-1:0]     wr_ptr,
  output logic              wrapped
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic              qual, rec, last;
  logic [AW-1:0]     base;
  logic [AW:0]       rsum;
  logic [AW-1:0]     raddr;

  always_comb begin
    case (mode)
      2'b00:   qual = 1'b1;
      2'b01:   qual = is_fetch;
      2'b10:   qual = is_mem;
      default: qual = is_io;
    endcase
  end

  assign rec  = cyc_valid & qual & ~freeze & ~halt_req;
  assign last = (wr_ptr == AW'(DEPTH - 1));

  always_ff @(posedge clk)
    if (rec) mem[wr_ptr] <= cyc_rec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      wrapped  <= 1'b0;
      sync     <= 1'b0;
      halt_req <= 1'b0;
      cnt      <= '0;
    end else begin
      sync <= rec;
      if (rec) begin
        wr_ptr <= last ? '0 : wr_ptr + 1'b1;
        if (last) wrapped <= 1'b1;
      end
      if (arm)
        cnt <= '0;
      else if (rec && cnt != CW'(STOP_AFTER))
        cnt <= cnt + 1'b1;
      if (arm || halt_clr)
        halt_req <= 1'b0;
      else if (rec && halt_en && cnt == CW'(STOP_AFTER - 1))
        halt_req <= 1'b1;
    end
  end

  assign base  = wrapped ? wr_ptr : '0;
  assign rsum  = {1'b0, base} + {1'b0, rd_idx};
  assign raddr = (rsum >= (AW+1)'(DEPTH)) ? AW'(rsum - (AW+1)'(DEPTH)) : rsum[AW-1:0];
  assign rd_data = mem[raddr];

  a_r7_freeze_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(wr_ptr));
  a_r4_no_sync_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> !sync);
  a_r3_ptr_moves_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |-> (wr_ptr == $past(wr_ptr)));
  a_r5_wrapped_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);
  a_r8_halt_blocks_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> $stable(wr_ptr));
  a_r9_no_halt_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_en |=> !$rose(halt_req));
  a_r11_clear_drops_halt: assert property (@(posedge clk) disable iff (!rst_n)
    halt_clr |=> !halt_req);

endmodule

// File: tb/tb_trace_ring.sv
module tb_trace_ring;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic halt_en = 0, arm = 0, halt_clr = 0, freeze = 0;
  logic cyc_valid = 0, is_fetch = 0, is_mem = 0, is_io = 0;
  logic [39:0] cyc_rec = '0;
  logic [6:0] rd_idx = '0;
  logic [39:0] rd_data;
  logic sync, halt_req, wrapped;
  logic [6:0] wr_ptr;

  trace_ring dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, seq = 1;
  logic [39:0] model [128];
  int eptr = 0, ecnt = 0;
  bit ewrap = 0, ehalt = 0;

  // {mode[1:0], valid, fetch, mem, io, expected store}
  localparam bit [6:0] VEC [0:11] = '{
    7'b00_1000_1, 7'b00_0110_0, 7'b01_1110_1, 7'b01_1010_0,
    7'b01_1001_0, 7'b10_1010_1, 7'b10_1110_1, 7'b10_1001_0,
    7'b11_1001_1, 7'b11_1010_0, 7'b11_0001_0, 7'b00_1001_1};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit qual_f(input logic [1:0] md, input bit v, f, m, io);
    case (md)
      2'b00: return v;
      2'b01: return v & f;
      2'b10: return v & m;
      default: return v & io;
    endcase
  endfunction

  task automatic step(input bit v, f, m, io, input bit exp_rec, input string req);
    logic [39:0] d;
    d = {8'(seq * 7), 32'(seq) * 32'h9E3779B1};
    cyc_valid = v; is_fetch = f; is_mem = m; is_io = io; cyc_rec = d;
    @(posedge clk); #1;
    if (exp_rec) begin
      model[eptr] = d;
      if (eptr == 127) ewrap = 1;
      if (ecnt == 63 && halt_en) ehalt = 1;
      if (ecnt != 64) ecnt++;
      eptr = (eptr + 1) % 128;
    end
    check(sync == exp_rec, {req, " sync R4"}, 64'(sync), 64'(exp_rec));
    check(wr_ptr == 7'(eptr), {req, " wr_ptr R3"}, 64'(wr_ptr), 64'(eptr));
    check(wrapped == ewrap, {req, " wrapped R5"}, 64'(wrapped), 64'(ewrap));
    check(halt_req == ehalt, {req, " halt_req R8"}, 64'(halt_req), 64'(ehalt));
    cyc_valid = 0; is_fetch = 0; is_mem = 0; is_io = 0;
    seq++;
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(1, 0, 1, 0, !freeze && !ehalt, req);
  endtask

  task automatic pulse(input bit is_arm);
    if (is_arm) arm = 1; else halt_clr = 1;
    @(posedge clk); #1;
    arm = 0; halt_clr = 0;
    ehalt = 0;
    if (is_arm) ecnt = 0;
  endtask

  task automatic readout(input string req);
    for (int i = 0; i < 128; i++) begin
      int idx, lim;
      lim = ewrap ? 128 : eptr;
      if (i >= lim) break;
      idx = ((ewrap ? eptr : 0) + i) % 128;
      rd_idx = 7'(i); #1;
      check(rd_data == model[idx], req, 64'(rd_data), 64'(model[idx]));
    end
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    check(wr_ptr == 0, "R1 wr_ptr", 64'(wr_ptr), 0);
    check(wrapped == 0, "R1 wrapped", 64'(wrapped), 0);
    check(sync == 0, "R1 sync", 64'(sync), 0);
    check(halt_req == 0, "R1 halt_req", 64'(halt_req), 0);
    rst_n = 1;

    // R2 qualification table
    foreach (VEC[k]) begin
      mode = VEC[k][6:5];
      check(qual_f(mode, VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1]) == VEC[k][0],
            "R2 table consistency", 64'(k), 64'(VEC[k][0]));
      step(VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0], "R2 mode vector");
    end
    mode = 0;
    readout("R6 read before wrap");

    // R5 fill past wrap
    run(130, "R5 fill");
    check(wrapped == 1, "R5 wrapped after fill", 64'(wrapped), 1);

    // R7 freeze: no recording, reads do not disturb
    freeze = 1;
    for (int i = 0; i < 5; i++) begin
      rd_idx = 7'(i * 31);
      step(1, 1, 1, 1, 0, "R7 frozen");
    end
    readout("R6 R7 dump oldest first");
    rd_idx = 7'd127; #1;
    check(rd_data == model[(eptr + 127) % 128], "R6 newest at last offset",
          64'(rd_data), 64'(model[(eptr + 127) % 128]));
    freeze = 0;

    // R8 halt after 64 words
    pulse(1);
    halt_en = 1;
    run(63, "R8 before 64th");
    check(halt_req == 0, "R8 no halt at 63", 64'(halt_req), 0);
    run(1, "R8 64th word");
    check(halt_req == 1, "R8 halt at 64", 64'(halt_req), 1);
    run(3, "R8 halted blocks store");
    readout("R8 contents while halted");

    // R11 clear resumes, no re-halt
    pulse(0);
    check(halt_req == 0, "R11 cleared", 64'(halt_req), 0);
    readout("R11 contents kept");
    run(70, "R11 resumed no re-halt");
    check(halt_req == 0, "R11 no re-halt before arm", 64'(halt_req), 0);

    // R10 re-arm restarts the count and keeps contents
    pulse(1);
    check(wrapped == 1, "R10 wrapped kept", 64'(wrapped), 1);
    readout("R10 contents kept after arm");
    run(64, "R10 count restarted");
    check(halt_req == 1, "R10 halt after re-arm", 64'(halt_req), 1);

    // R9 halt disabled
    halt_en = 0;
    pulse(1);
    run(70, "R9 disabled");
    check(halt_req == 0, "R9 never halts", 64'(halt_req), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule